// File: doc/BRIEF.md
# Preloaded Up-Counting Interval Timer

This block is a 16-bit interval timer driven through a byte-wide register port. Software writes a reload value, selects one of three control modes (clear, hold, run) and programs an interrupt control byte carrying an enable bit and a 3-bit request level. In run mode the counter climbs by one on every cycle where the tick enable is high. When it steps past its all-ones value it reloads from the stored reload value and latches a pending interrupt.

The pending flag stays set until software writes a one to its bit in the interrupt control byte. An external interrupt controller sees a request line, which is high while the flag is pending and enabled, together with the programmed level. With a 160 kHz tick, a reload value of 65536 - 160000/f gives a period of f Hz. For example, 63936 gives 100 Hz.

Top module: `interval_timer`

## Requirements
- R1: After reset the reload value, the live count, the control mode and the whole interrupt control byte read as zero, and `irq_o` is low.
- R2: The reload value is written and read as two bytes: offset 0 holds bits 15:8 and offset 1 holds bits 7:0.
- R3: In run mode (control value 3, written at offset 5) the count rises by exactly one on each clock edge where `tick` is high, and it keeps its value when `tick` is low. The count reads back at offset 2 (bits 15:8) and offset 3 (bits 7:0).
- R4: In run mode, a tick that arrives while the count is 0xFFFF loads the reload value into the count and sets the pending flag on that same edge.
- R5: Control value 1 holds the count at its current value whatever `tick` does. Control value 2 behaves the same way.
- R6: Control value 0 forces the count to zero and keeps it there, even while ticks arrive.
- R7: The interrupt control byte at offset 4 reads as {pending, 3'b000, enable, level[2:0]}. Writing it with bit 7 set clears the pending flag. Writing it with bit 7 clear leaves the pending flag unchanged. Both writes update the enable bit and the level field.
- R8: `irq_o` is high only while the flag is pending and the enable bit (bit 3) is set. `irq_lvl_o` always carries the level field.
- R9: If an acknowledge write and an overflow occur in the same cycle, the flag stays pending.
- R10: Writing the reload value does not change the live count. The new value is loaded at the next overflow.
- R11: Writes to the count bytes (offsets 2 and 3) are ignored. Offsets 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count enable at the timer rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register at `addr` |
| irq_o | output | 1 | Interrupt request (pending and enabled) |
| irq_lvl_o | output | 3 | Programmed request level |

## Verification
The assertions assume that every input is a clean, synchronous level at the clock edge and that `tick` is high for at most one cycle per timer period. The assertions themselves do not depend on the tick rate. The bench drives every input half a cycle away from the rising edge. It holds `tick` high for long runs only to reach the all-ones count in reasonable time, which is legal because nothing in the block relies on gaps between ticks. Acknowledge writes are placed deliberately on the overflow cycle to exercise the collision rule.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_o,
  output logic [2:0]    irq_lvl_o
);
  localparam logic [AW-1:0] A_PHI = AW'(0);
  localparam logic [AW-1:0] A_PLO = AW'(1);
  localparam logic [AW-1:0] A_CHI = AW'(2);
  localparam logic [AW-1:0] A_CLO = AW'(3);
  localparam logic [AW-1:0] A_ICR = AW'(4);
  localparam logic [AW-1:0] A_CTL = AW'(5);

  logic [CW-1:0] pre_q, cnt_q, cnt_nxt;
  logic [1:0]    ctl_q;
  logic          ien_q, pend_q;
  logic [2:0]    lvl_q;
  logic          run, wrap, ack;

  assign run  = (ctl_q == 2'b11);
  assign wrap = run & tick & (&cnt_q);
  assign ack  = wr_en & (addr == A_ICR) & wdata[7];

  always_comb begin
    if (ctl_q == 2'b00)  cnt_nxt = '0;
    else if (run & tick) cnt_nxt = wrap ? pre_q : cnt_q + CW'(1);
    else                 cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      ctl_q  <= 2'b00;
      ien_q  <= 1'b0;
      lvl_q  <= 3'd0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      pend_q <= wrap | (pend_q & ~ack);
      if (wr_en) begin
        case (addr)
          A_PHI: pre_q[CW-1:8] <= wdata;
          A_PLO: pre_q[7:0]    <= wdata;
          A_ICR: begin
            ien_q <= wdata[3];
            lvl_q <= wdata[2:0];
          end
          A_CTL: ctl_q <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_PHI:   rdata = pre_q[CW-1:8];
      A_PLO:   rdata = pre_q[7:0];
      A_CHI:   rdata = cnt_q[CW-1:8];
      A_CLO:   rdata = cnt_q[7:0];
      A_ICR:   rdata = {pend_q, 3'b000, ien_q, lvl_q};
      A_CTL:   rdata = {6'd0, ctl_q};
      default: rdata = 8'h00;
    endcase
  end

  assign irq_o     = pend_q & ien_q;
  assign irq_lvl_o = lvl_q;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic        irq_o,
  input logic [15:0] count,
  input logic [15:0] preload,
  input logic [1:0]  ctl,
  input logic        pend
);
  logic ovf_now, ack_now;
  assign ovf_now = (ctl == 2'b11) && tick && (count == 16'hFFFF);
  assign ack_now = wr_en && (addr == 3'd4) && wdata[7];

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl == 2'b11) && tick && (count != 16'hFFFF)) |=> (count == $past(count) + 16'd1));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_now |=> (pend && count == $past(preload)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 2'b01 || ctl == 2'b10) |=> $stable(count));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 2'b00) |=> (count == 16'h0000));

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_now && !ovf_now) |=> !pend);

  p_irq_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend);

  p_ack_loses_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_now && ovf_now) |=> pend);

  p_pend_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ovf_now));
endmodule

bind interval_timer interval_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq_o(irq_o), .count(cnt_q), .preload(pre_q),
  .ctl(ctl_q), .pend(pend_q)
);

// File: tb/interval_timer_tb_top.sv
`timescale 1ns/100ps
module interval_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq_o;
  logic [2:0] irq_lvl_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .irq_lvl_o(irq_lvl_o)
  );

  // behavioural reference
  int unsigned m_cnt, m_pre, m_ctl, m_lvl;
  bit m_en, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_ctl = 0; m_lvl = 0; m_en = 0; m_pend = 0;
    end else begin
      bit ovf;
      ovf = (m_ctl == 3) && tick && (m_cnt == 65535);
      if (m_ctl == 0) m_cnt = 0;
      else if (m_ctl == 3 && tick) m_cnt = ovf ? m_pre : m_cnt + 1;
      if (ovf) m_pend = 1;
      else if (wr_en && addr == 4 && wdata[7]) m_pend = 0;
      if (wr_en) begin
        case (addr)
          0: m_pre = (m_pre & 'hFF) | (int'(wdata) << 8);
          1: m_pre = (m_pre & 'hFF00) | int'(wdata);
          4: begin m_en = wdata[3]; m_lvl = wdata[2:0]; end
          5: m_ctl = wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic int unsigned model_read(input logic [2:0] a);
    case (a)
      0: return (m_pre >> 8) & 'hFF;
      1: return m_pre & 'hFF;
      2: return (m_cnt >> 8) & 'hFF;
      3: return m_cnt & 'hFF;
      4: return (int'(m_pend) << 7) | (int'(m_en) << 3) | m_lvl;
      5: return m_ctl;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int unsigned act, input int unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R8", "irq_o vs model", irq_o, m_pend && m_en);
      check("R8", "irq_lvl_o vs model", irq_lvl_o, m_lvl);
      check("R3", "rdata vs model", rdata, model_read(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int unsigned exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, $sformatf("read offset %0d", a), rdata, exp);
  endtask

  task automatic rd16(input logic [2:0] a, input int unsigned exp, input string req);
    rd(a, (exp >> 8) & 'hFF, req);
    rd(a + 3'd1, exp & 'hFF, req);
  endtask

  task automatic ticks(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (gaps) begin @(negedge clk); @(negedge clk); end
    end
  endtask

  task automatic tick_run(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd16(3'd0, 0, "R1");
    rd16(3'd2, 0, "R1");
    rd(3'd4, 0, "R1");
    rd(3'd5, 0, "R1");
    check("R1", "irq_o after reset", irq_o, 0);
    // R2 reload bytes
    wr(3'd0, 8'hFF); wr(3'd1, 8'hF0);
    rd16(3'd0, 16'hFFF0, "R2");
    // R3 run with gaps
    wr(3'd5, 8'h03);
    ticks(5, 1'b1);
    rd16(3'd2, 5, "R3");
    repeat (4) @(negedge clk);
    rd16(3'd2, 5, "R3");
    // R5 hold with value 1 and value 2
    wr(3'd5, 8'h01);
    ticks(4, 1'b0);
    rd16(3'd2, 5, "R5");
    wr(3'd5, 8'h02);
    ticks(4, 1'b0);
    rd16(3'd2, 5, "R5");
    // R6 clear while ticking
    wr(3'd5, 8'h00);
    ticks(3, 1'b0);
    rd16(3'd2, 0, "R6");
    // R7 interrupt control readback
    wr(3'd4, 8'h0D);
    rd(3'd4, 8'h0D, "R7");
    check("R8", "irq_lvl_o level", irq_lvl_o, 5);
    check("R8", "irq_o idle", irq_o, 0);
    // R4 first overflow from zero
    wr(3'd5, 8'h03);
    tick_run(65535);
    rd16(3'd2, 16'hFFFF, "R4");
    rd(3'd4, 8'h0D, "R4");
    tick_run(1);
    rd16(3'd2, 16'hFFF0, "R4");
    rd(3'd4, 8'h8D, "R4");
    check("R8", "irq_o pending and enabled", irq_o, 1);
    // R7/R8 write without ack bit, disable
    wr(3'd4, 8'h05);
    rd(3'd4, 8'h85, "R7");
    check("R8", "irq_o disabled", irq_o, 0);
    wr(3'd4, 8'h8D);
    rd(3'd4, 8'h0D, "R7");
    check("R8", "irq_o after ack", irq_o, 0);
    // R11 count is read-only; spare offsets read zero
    wr(3'd5, 8'h01);
    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    rd16(3'd2, 16'hFFF0, "R11");
    wr(3'd6, 8'hAA);
    rd(3'd6, 0, "R11");
    rd(3'd7, 0, "R11");
    // R10 reload write does not touch count
    wr(3'd5, 8'h03);
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rd16(3'd2, 16'hFFF0, "R10");
    ticks(15, 1'b0);
    rd16(3'd2, 16'hFFFF, "R10");
    // R9 raise pending, then ack on overflow cycle
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd4; wdata = 8'h8D;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd4, 8'h8D, "R9");
    rd16(3'd2, 16'h1234, "R10");
    check("R9", "irq_o after collision", irq_o, 1);
    wr(3'd4, 8'h8D);
    rd(3'd4, 8'h0D, "R7");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule